// File: doc/BRIEF.md
# DMA Channel Control and Sequencing

This block sequences one DMA channel. Software programs a 24-bit control word and two length registers through a small register port. The sequencer then decides when a transfer unit begins and how many words it moves. A unit is one word, one line or one block. The control word selects among three ways to begin a unit. In the first, setting the enable bit starts a block at once. In the second, setting enable only arms the channel, and one of 32 request lines then triggers each unit. In the third, the enable bit stays set after a unit, so further requests keep the channel running.

The block drives a simple word handshake towards an external datapath. That datapath generates the addresses and moves the data. The sequencer counts the words the datapath stores and flags the last one. It can clear enable in hardware when a unit ends, and it can raise a one-cycle completion interrupt. A software clear of enable never cuts a word short: the word in flight is stored first, and only then does the channel stop.

Fields that matter only to the datapath are stored and read back unchanged. These are priority, continuous mode, 3D mode, address mode and the memory spaces.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every readable register reads zero, and `busy`, `xfer_valid`, `xfer_last` and `done_irq` are low.
- R2: Register port selectors:
  - `cfg_sel` 0 is the control word, and all 24 bits read back as written.
  - `cfg_sel` 1 is the block length minus one.
  - `cfg_sel` 2 is the line length minus one.
  - Both length registers are `CNT_W` bits wide and read back zero-extended.
  - `cfg_sel` 3 reads zero.
- R3: Mode field is bits 21:19, and enable is bit 23. In mode 011, a control write that sets enable while enable was clear starts a block on that clock edge. The block moves block-length-plus-one words.
- R4: In request modes (000, 001, 010, 100, 101, 110), setting enable only arms the channel. The request line is chosen by bits 15:11. A request seen high at one rising edge while enabled makes `busy` rise on the next rising edge. No other event starts a unit in these modes.
- R5: Unit size follows the mode:
  - Modes 001 and 101 move one word.
  - Modes 010 and 110 move line-length-plus-one words.
  - Modes 000, 011 and 100 move block-length-plus-one words.
- R6: Modes 000 to 011 clear enable in hardware after the last word of the unit, and readback shows the cleared bit. Modes 100 to 110 leave enable set, so later requests start later units.
- R7: A request that arrives while a unit runs is remembered and served right after that unit ends. Requests seen while enable is clear, and requests on lines that are not selected, are dropped.
- R8: If software clears enable during a unit, exactly one more word (the one in flight) completes. The channel then goes idle with no interrupt.
- R9: Interrupt enable is bit 22. When it is set, `done_irq` pulses high for one cycle after the last word of each block unit. Word and line units never raise it.
- R10: Mode 111 never starts a unit, whatever the enable bit or the requests.
- R11: `xfer_valid` is high exactly while `busy` is high. A word is stored on a rising edge where both `xfer_valid` and `xfer_done` are high. `xfer_last` is high only while the final word of a unit is offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 control, 1 block length, 2 line length) |
| cfg_wdata | input | 24 | Register write data |
| cfg_rdata | output | 24 | Register read data for `cfg_sel` |
| req_in | input | REQ_NUM | Peripheral request lines |
| xfer_valid | output | 1 | A word is offered to the datapath |
| xfer_last | output | 1 | The offered word is the last of the unit |
| xfer_done | input | 1 | Datapath has stored the offered word |
| busy | output | 1 | A unit is in progress |
| done_irq | output | 1 | One-cycle block completion interrupt |

## Verification
The bench pauses the datapath, clears enable in the middle of a block, and then expects exactly one more stored word. A design that stopped at once would lose that word, and one that ignored the clear would run the block to its end.

A second request arrives while a block is still running, in a mode that keeps enable set. A design without the pending flag would move only one block and raise one interrupt instead of two.

Requests are also pulsed while the channel is disabled and on unselected lines. A design that latched them would start later without cause.

Randomised runs cover every mode with zero and non-zero lengths. They check the word count, the last-word marker, the interrupt count and the final enable readback, so a wrong mode table or an off-by-one length shows up at once.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   localparam int CTRL_W   = 24;
   localparam int EN_BIT   = 23;
   localparam int IE_BIT   = 22;
   localparam int MODE_LSB = 19;
   localparam int MODE_W   = 3;
   localparam int SRC_LSB  = 11;
   localparam int SRC_W    = 5;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_BLK  = 2'd1;
   localparam logic [1:0] SEL_LINE = 2'd2;

   localparam logic [MODE_W-1:0] MODE_SW_BLOCK = 3'b011;

   typedef enum logic [1:0] {
      UNIT_NONE  = 2'd0,
      UNIT_WORD  = 2'd1,
      UNIT_LINE  = 2'd2,
      UNIT_BLOCK = 2'd3
   } unit_e;

   typedef struct packed {
      unit_e unit;
      logic  sw_start;
      logic  auto_clr;
   } mode_info_t;

   typedef enum logic {
      S_IDLE = 1'b0,
      S_RUN  = 1'b1
   } seq_state_e;

   function automatic mode_info_t decode_mode(input logic [MODE_W-1:0] m);
      mode_info_t r;
      r.unit     = UNIT_NONE;
      r.sw_start = 1'b0;
      r.auto_clr = 1'b0;
      case (m)
         3'b000: begin r.unit = UNIT_BLOCK; r.auto_clr = 1'b1; end
         3'b001: begin r.unit = UNIT_WORD;  r.auto_clr = 1'b1; end
         3'b010: begin r.unit = UNIT_LINE;  r.auto_clr = 1'b1; end
         3'b011: begin r.unit = UNIT_BLOCK; r.auto_clr = 1'b1; r.sw_start = 1'b1; end
         3'b100: r.unit = UNIT_BLOCK;
         3'b101: r.unit = UNIT_WORD;
         3'b110: r.unit = UNIT_LINE;
         default: r.unit = UNIT_NONE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
   import dma_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        sel,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              hw_clr_en,
   output logic [CTRL_W-1:0] ctrl,
   output logic [CNT_W-1:0]  blk_len,
   output logic [CNT_W-1:0]  line_len,
   output logic              sw_start,
   output logic [CTRL_W-1:0] rdata
);

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  blk_q;
   logic [CNT_W-1:0]  line_q;
   logic [CTRL_W-1:0] blk_rd;
   logic [CTRL_W-1:0] line_rd;
   logic              wr_ctrl;
   mode_info_t        wr_info;

   assign wr_ctrl = we && (sel == SEL_CTRL);
   assign wr_info = decode_mode(wdata[MODE_LSB +: MODE_W]);
   // start strobe: enable goes from clear to set in the software-triggered mode
   assign sw_start = wr_ctrl && wdata[EN_BIT] && !ctrl_q[EN_BIT] && wr_info.sw_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         blk_q  <= '0;
         line_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q <= wdata;
         end else if (hw_clr_en) begin
            ctrl_q[EN_BIT] <= 1'b0;
         end
         if (we && (sel == SEL_BLK))  blk_q  <= wdata[CNT_W-1:0];
         if (we && (sel == SEL_LINE)) line_q <= wdata[CNT_W-1:0];
      end
   end

   generate
      if (CNT_W == CTRL_W) begin : g_full_width
         assign blk_rd  = blk_q;
         assign line_rd = line_q;
      end else begin : g_pad_width
         assign blk_rd  = {{(CTRL_W-CNT_W){1'b0}}, blk_q};
         assign line_rd = {{(CTRL_W-CNT_W){1'b0}}, line_q};
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_CTRL: rdata = ctrl_q;
         SEL_BLK:  rdata = blk_rd;
         SEL_LINE: rdata = line_rd;
         default:  rdata = '0;
      endcase
   end

   assign ctrl     = ctrl_q;
   assign blk_len  = blk_q;
   assign line_len = line_q;

   AST_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clr_en && !wr_ctrl) |=> !ctrl_q[EN_BIT]) else $error("enable not cleared"); // R6
   AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ctrl_q == $past(wdata))) else $error("control write lost"); // R2

endmodule

// File: rtl/dma_req_pend.sv
module dma_req_pend
   import dma_chan_pkg::*;
#(
   parameter int REQ_NUM     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REQ_NUM-1:0] req_in,
   input  logic [SRC_W-1:0]   src,
   input  logic               en,
   input  logic               consume,
   output logic               pend
);

   logic [REQ_NUM-1:0] req_s;
   logic               req_sel;
   logic               pend_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign req_s = req_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][REQ_NUM-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= req_in;
               for (int s = 1; s < SYNC_STAGES; s++) begin
                  sync_q[s] <= sync_q[s-1];
               end
            end
         end
         assign req_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_comb begin
      req_sel = 1'b0;
      for (int i = 0; i < REQ_NUM; i++) begin
         if (src == SRC_W'(i)) req_sel = req_s[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (!en) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= (pend_q && !consume) || req_sel;
      end
   end

   assign pend = pend_q;

   AST_DROP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pend_q) else $error("request kept while disabled"); // R7
   AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pend_q && !consume) |=> pend_q) else $error("pending request lost"); // R7

endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ie,
   input  logic [MODE_W-1:0] mode,
   input  logic [CNT_W-1:0]  blk_len,
   input  logic [CNT_W-1:0]  line_len,
   input  logic              sw_start,
   input  logic              pend,
   input  logic              xfer_done,
   output logic              busy,
   output logic              xfer_valid,
   output logic              xfer_last,
   output logic              irq,
   output logic              hw_clr_en,
   output logic              consume
);

   seq_state_e       state_q;
   logic [CNT_W-1:0] rem_q;
   mode_info_t       run_q;
   logic             irq_q;

   mode_info_t       mi;
   mode_info_t       go_info;
   logic             idle;
   logic             sw_go;
   logic             req_go;
   logic             word_done;
   logic             unit_end;
   logic [CNT_W-1:0] load_len;

   assign mi        = decode_mode(mode);
   assign idle      = (state_q == S_IDLE);
   assign sw_go     = idle && sw_start;
   assign req_go    = idle && !sw_start && en && pend &&
                      (mi.unit != UNIT_NONE) && !mi.sw_start;
   assign consume   = req_go;
   assign word_done = (state_q == S_RUN) && xfer_done;
   assign unit_end  = word_done && (rem_q == '0);
   assign hw_clr_en = unit_end && run_q.auto_clr;
   assign go_info   = sw_go ? decode_mode(MODE_SW_BLOCK) : mi;

   always_comb begin
      if (sw_go) begin
         load_len = blk_len;
      end else begin
         case (mi.unit)
            UNIT_WORD: load_len = '0;
            UNIT_LINE: load_len = line_len;
            default:   load_len = blk_len;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         rem_q   <= '0;
         run_q   <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= unit_end && ie && (run_q.unit == UNIT_BLOCK);
         case (state_q)
            S_IDLE: begin
               if (sw_go || req_go) begin
                  state_q <= S_RUN;
                  rem_q   <= load_len;
                  run_q   <= go_info;
               end
            end
            default: begin
               if (word_done) begin
                  if ((rem_q == '0) || !en) begin
                     state_q <= S_IDLE;
                  end else begin
                     rem_q <= rem_q - 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign busy       = (state_q == S_RUN);
   assign xfer_valid = (state_q == S_RUN);
   assign xfer_last  = (state_q == S_RUN) && (rem_q == '0);
   assign irq        = irq_q;

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q) else $error("interrupt longer than one cycle"); // R9
   AST_STOP_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !en) |=> (state_q == S_IDLE)) else $error("kept running after clear"); // R8
   AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && (mode == 3'b111) && !sw_start) |=> (state_q == S_IDLE)) else $error("reserved mode ran"); // R10
   AST_ARM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !pend && !sw_start) |=> (state_q == S_IDLE)) else $error("start without trigger"); // R4
   AST_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_last && !xfer_done) |=> xfer_last) else $error("last marker dropped"); // R11

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_chan_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int REQ_NUM     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [23:0]        cfg_wdata,
   output logic [23:0]        cfg_rdata,
   input  logic [REQ_NUM-1:0] req_in,
   output logic               xfer_valid,
   output logic               xfer_last,
   input  logic               xfer_done,
   output logic               busy,
   output logic               done_irq
);

   generate
      if (CNT_W < 1 || CNT_W > CTRL_W) begin : g_bad_cnt
         $error("CNT_W must lie between 1 and the control width");
      end
      if (REQ_NUM < 1 || REQ_NUM > (1 << SRC_W)) begin : g_bad_req
         $error("REQ_NUM must be reachable by the source field");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 0 and 4");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl;
   logic [CNT_W-1:0]  blk_len;
   logic [CNT_W-1:0]  line_len;
   logic              sw_start;
   logic              hw_clr_en;
   logic              pend;
   logic              consume;

   dma_cfg_regs #(.CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .sel       (cfg_sel),
      .wdata     (cfg_wdata),
      .hw_clr_en (hw_clr_en),
      .ctrl      (ctrl),
      .blk_len   (blk_len),
      .line_len  (line_len),
      .sw_start  (sw_start),
      .rdata     (cfg_rdata)
   );

   dma_req_pend #(.REQ_NUM(REQ_NUM), .SYNC_STAGES(SYNC_STAGES)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_in  (req_in),
      .src     (ctrl[SRC_LSB +: SRC_W]),
      .en      (ctrl[EN_BIT]),
      .consume (consume),
      .pend    (pend)
   );

   dma_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ctrl[EN_BIT]),
      .ie         (ctrl[IE_BIT]),
      .mode       (ctrl[MODE_LSB +: MODE_W]),
      .blk_len    (blk_len),
      .line_len   (line_len),
      .sw_start   (sw_start),
      .pend       (pend),
      .xfer_done  (xfer_done),
      .busy       (busy),
      .xfer_valid (xfer_valid),
      .xfer_last  (xfer_last),
      .irq        (done_irq),
      .hw_clr_en  (hw_clr_en),
      .consume    (consume)
   );

   AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid == busy) else $error("valid and busy disagree"); // R11
   AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> $past(ctrl[IE_BIT])) else $error("interrupt without enable"); // R9

endmodule

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [23:0] cfg_wdata = '0;
   wire  [23:0] cfg_rdata;
   logic [31:0] req_in = '0;
   logic        xfer_done = 1'b0;
   wire         xfer_valid, xfer_last, busy, done_irq;

   int n_chk = 0, n_fail = 0;
   int words = 0, lasts = 0, irqs = 0;
   bit resp_en = 1'b0;
   int resp_rate = 2;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dma_chan_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_in(req_in),
      .xfer_valid(xfer_valid), .xfer_last(xfer_last), .xfer_done(xfer_done),
      .busy(busy), .done_irq(done_irq)
   );

   // datapath model: decides after each falling edge, consumed at the next rising edge
   always @(negedge clk) begin
      #1;
      xfer_done = resp_en && xfer_valid && (($urandom % resp_rate) == 0);
      if (xfer_done) begin
         words++;
         if (xfer_last) lasts++;
      end
      if (done_irq) irqs++;
   end

   function automatic logic [23:0] ctrl_word(input bit en, input bit ie,
                                             input int mode, input int src);
      logic [23:0] w;
      w = '0;
      w[23] = en;
      w[22] = ie;
      w[21:19] = mode[2:0];
      w[15:11] = src[4:0];
      return w;
   endfunction

   function automatic int exp_words(input int mode, input int blk, input int line);
      if (mode == 1 || mode == 5) return 1;
      if (mode == 2 || mode == 6) return line + 1;
      if (mode == 7) return 0;
      return blk + 1;
   endfunction

   function automatic int exp_irqs(input int mode, input bit ie);
      return (ie && (mode == 0 || mode == 3 || mode == 4)) ? 1 : 0;
   endfunction

   function automatic int exp_en_after(input int mode);
      return (mode <= 3) ? 0 : 1;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [23:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [1:0] sel, output logic [23:0] data);
      @(negedge clk);
      cfg_sel = sel;
      #1;
      data = cfg_rdata;
   endtask

   task automatic pulse_req(input int idx);
      @(negedge clk);
      req_in[idx] = 1'b1;
      @(negedge clk);
      req_in[idx] = 1'b0;
   endtask

   task automatic wait_idle();
      int quiet;
      quiet = 0;
      repeat (4) @(negedge clk);
      while (quiet < 3) begin
         @(negedge clk);
         quiet = busy ? 0 : quiet + 1;
      end
   endtask

   task automatic clear_counts();
      words = 0; lasts = 0; irqs = 0;
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
   end

   initial begin
      logic [23:0] rd;
      logic [23:0] v;
      int w0;
      void'($urandom(32'h1d5a));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cfg_read(2'd0, rd); check("R1 ctrl", rd, 0);
      cfg_read(2'd1, rd); check("R1 blk", rd, 0);
      cfg_read(2'd2, rd); check("R1 line", rd, 0);
      check("R1 busy", busy, 0);
      check("R1 valid", xfer_valid, 0);
      check("R1 irq", done_irq, 0);

      // R2 register readback
      v = $urandom;
      v[23] = 1'b0;
      cfg_write(2'd0, v);
      cfg_read(2'd0, rd); check("R2 ctrl readback", rd, v);
      cfg_write(2'd1, 24'hABCDEF);
      cfg_read(2'd1, rd); check("R2 blk zero-ext", rd, 24'h00CDEF);
      cfg_write(2'd2, 24'h123456);
      cfg_read(2'd2, rd); check("R2 line zero-ext", rd, 24'h003456);
      cfg_read(2'd3, rd); check("R2 sel3", rd, 0);
      cfg_write(2'd0, 24'h0);
      check("R2 no start", busy, 0);

      // R3 software-triggered block
      resp_en = 1'b1; resp_rate = 2;
      cfg_write(2'd1, 24'd4);
      clear_counts();
      cfg_write(2'd0, ctrl_word(1, 1, 3, 0));
      check("R3 busy after start write", busy, 1);
      wait_idle();
      check("R3 words", words, 5);
      check("R11 last count", lasts, 1);
      check("R9 block irq", irqs, 1);
      cfg_read(2'd0, rd); check("R6 enable cleared mode 011", rd[23], 0);

      // R4 arming and request latency, R7 wrong line
      cfg_write(2'd1, 24'd2);
      clear_counts();
      cfg_write(2'd0, ctrl_word(1, 1, 0, 5));
      repeat (6) @(negedge clk);
      check("R4 armed only busy", busy, 0);
      check("R4 armed only words", words, 0);
      pulse_req(6);
      repeat (4) @(negedge clk);
      check("R7 unselected line ignored", busy + words, 0);
      pulse_req(5);
      check("R4 not yet busy", busy, 0);
      @(negedge clk);
      check("R4 busy next edge", busy, 1);
      wait_idle();
      check("R5 block words", words, 3);
      check("R9 irq mode 000", irqs, 1);
      cfg_read(2'd0, rd); check("R6 enable cleared mode 000", rd[23], 0);

      // R5/R6 word mode with enable kept
      clear_counts();
      cfg_write(2'd0, ctrl_word(1, 1, 5, 9));
      for (int k = 0; k < 3; k++) begin
         pulse_req(9);
         wait_idle();
      end
      check("R5 word units", words, 3);
      check("R11 last per word", lasts, 3);
      check("R9 no irq for words", irqs, 0);
      cfg_read(2'd0, rd); check("R6 enable kept mode 101", rd[23], 1);
      cfg_write(2'd0, 24'h0);

      // R5 line mode
      cfg_write(2'd2, 24'd3);
      clear_counts();
      cfg_write(2'd0, ctrl_word(1, 1, 6, 31));
      pulse_req(31); wait_idle();
      pulse_req(31); wait_idle();
      check("R5 line words", words, 8);
      check("R9 no irq for lines", irqs, 0);
      cfg_read(2'd0, rd); check("R6 enable kept mode 110", rd[23], 1);
      cfg_write(2'd0, 24'h0);

      // R7 request while running is held
      cfg_write(2'd1, 24'd5);
      resp_rate = 3;
      clear_counts();
      cfg_write(2'd0, ctrl_word(1, 1, 4, 2));
      pulse_req(2);
      repeat (2) @(negedge clk);
      check("R7 running before second request", busy, 1);
      pulse_req(2);
      wait_idle();
      check("R7 two blocks", words, 12);
      check("R9 two irqs", irqs, 2);
      cfg_write(2'd0, 24'h0);

      // R7 request while disabled dropped
      clear_counts();
      cfg_write(2'd0, ctrl_word(0, 0, 0, 2));
      pulse_req(2);
      cfg_write(2'd0, ctrl_word(1, 0, 0, 2));
      repeat (6) @(negedge clk);
      check("R7 disabled request dropped", busy + words, 0);
      cfg_write(2'd0, 24'h0);

      // R8 software clear in the middle of a block
      cfg_write(2'd1, 24'd19);
      resp_rate = 2;
      clear_counts();
      cfg_write(2'd0, ctrl_word(1, 1, 3, 0));
      repeat (6) @(negedge clk);
      resp_en = 1'b0;
      @(negedge clk);
      cfg_write(2'd0, ctrl_word(0, 1, 3, 0));
      w0 = words;
      check("R8 still busy after clear", busy, 1);
      resp_en = 1'b1;
      wait_idle();
      check("R8 one more word", words, w0 + 1);
      check("R8 no irq", irqs, 0);
      cfg_read(2'd0, rd); check("R8 enable reads clear", rd[23], 0);

      // R10 reserved mode
      clear_counts();
      cfg_write(2'd0, ctrl_word(1, 1, 7, 1));
      pulse_req(1);
      repeat (5) @(negedge clk);
      check("R10 reserved idle", busy + words, 0);
      cfg_read(2'd0, rd); check("R10 readback", rd, ctrl_word(1, 1, 7, 1));
      cfg_write(2'd0, 24'h0);

      // randomised runs across all modes
      for (int it = 0; it < 24; it++) begin
         int mode, blk, line, src;
         bit ie;
         mode = $urandom % 7;
         blk  = $urandom % 8;
         line = $urandom % 5;
         src  = $urandom % 32;
         ie   = $urandom % 2;
         resp_rate = 1 + ($urandom % 3);
         cfg_write(2'd1, 24'(blk));
         cfg_write(2'd2, 24'(line));
         clear_counts();
         cfg_write(2'd0, ctrl_word(1, ie, mode, src));
         if (mode != 3) pulse_req(src);
         wait_idle();
         check($sformatf("R5 random words mode %0d", mode), words, exp_words(mode, blk, line));
         check($sformatf("R11 random last mode %0d", mode), lasts, 1);
         check($sformatf("R9 random irq mode %0d", mode), irqs, exp_irqs(mode, ie));
         cfg_read(2'd0, rd);
         check($sformatf("R6 random enable mode %0d", mode), rd[23], exp_en_after(mode));
         cfg_write(2'd0, 24'h0);
      end

      finish_up();
   end

endmodule